// File: doc/BRIEF.md
# Capture Sample Ring Buffer with Host Memory Window

This block stores a stream of 4-bit receiver samples in a small on-chip memory that it treats as a circular buffer. Each valid sample goes to the location named by a write pointer. The pointer then advances and wraps back to zero at the end of the memory, so the oldest data is overwritten continuously.

A host processor sees the buffer as ordinary memory on an external asynchronous SRAM-style bus. The bus uses chip select, read strobe, write strobe, address and a bidirectional data bus, and other memories share the same address and data lines. The block drives the data lines only while it is selected for a read and leaves them released at all other times.

One address bit splits the host window into two regions: sample storage and a control/status region. A read of the control region returns the current write pointer and a wrap flag, so the host can locate the newest sample. A host write to the control region clears the wrap flag.

Top module: `cap_ring_buf`

## Requirements
- R1: After reset the write pointer is 0, the wrap flag is 0 and the data bus is released.
- R2: Each cycle with `smp_valid` high stores `smp_data` at the write pointer, and the pointer then advances by one modulo DEPTH (512). Cycles without `smp_valid` leave the pointer unchanged.
- R3: A read with `bus_addr[9]` = 0 returns the sample stored at index `bus_addr[8:0]` on `bus_data[3:0]`, with bits 15..4 at zero. The data is valid from the first clock edge on which select and read strobe are both low, and it stays valid while they remain low.
- R4: The memory reads before it writes. If a host read and a sample write hit the same index on the same edge, the read returns the old contents.
- R5: A read with `bus_addr[9]` = 1 returns a status word. Bits 8..0 hold the write pointer, bit 15 holds the wrap flag and the other bits are zero.
- R6: The wrap flag is set when a valid sample moves the pointer from 511 to 0. It stays set until the host clears it.
- R7: A host write (`bus_cs_n`=0, `bus_wr_n`=0) with `bus_addr[9]`=1 clears the wrap flag. If a wrap happens on the same edge, the set wins.
- R8: Host writes with `bus_addr[9]`=0 are ignored. The sample memory keeps its contents.
- R9: The block drives `bus_data` only while `bus_cs_n` and `bus_rd_n` are both low. At all other times it releases the lines, so another device can drive them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | 4 | Packed sample value |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_addr | input | 10 | Host address; bit 9 selects the control region |
| bus_data | inout | 16 | Shared host data bus, three-state |

## Verification
The buffer is filled with a position-dependent pattern, (7·i+3) mod 16. This catches address swaps, and the read-back values show both the index decode and the zero upper bits. The status word is read after a partial fill and after a full lap, which separates correct pointer counting from correct wrap detection. A read that collides with a sample write on the same index tells read-first behaviour apart from write-first. To test bus release, the bench drives a foreign pattern onto the bus while the block should be off and checks that the pattern arrives intact; a block that drives the bus at those times corrupts it.

// File: rtl/cap_ring_pkg.sv
package cap_ring_pkg;

   typedef enum logic {
      RGN_SAMPLE = 1'b0,
      RGN_CTRL   = 1'b1
   } cap_rgn_e;

   function automatic cap_rgn_e rgn_of(input logic msb);
      return msb ? RGN_CTRL : RGN_SAMPLE;
   endfunction

endpackage

// File: rtl/cap_wptr.sv
module cap_wptr #(
   parameter int DEPTH = 512,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          clr_wrap,
   output logic [PW-1:0] ptr,
   output logic          wrap
);

   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic at_end;
   assign at_end = (ptr == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr  <= '0;
         wrap <= 1'b0;
      end else begin
         if (adv) ptr <= ptr + 1'b1;
         if (adv && at_end) wrap <= 1'b1;
         else if (clr_wrap) wrap <= 1'b0;
      end
   end

endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
   parameter int DEPTH = 512,
   parameter int SW    = 4,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [PW-1:0] waddr,
   input  logic [SW-1:0] wdata,
   input  logic          re,
   input  logic [PW-1:0] raddr,
   output logic [SW-1:0] rdata
);

   logic [SW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/cap_busio.sv
module cap_busio #(
   parameter int DW = 16
) (
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic [DW-1:0] dout,
   output logic          oe,
   inout  wire  [DW-1:0] pad
);

   assign oe  = !cs_n && !rd_n;
   assign pad = oe ? dout : {DW{1'bz}};

endmodule

// File: rtl/cap_ring_buf.sv
module cap_ring_buf
   import cap_ring_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int SW    = 4,
   parameter int DW    = 16,
   localparam int PW = $clog2(DEPTH),
   localparam int AW = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic [SW-1:0] smp_data,
   input  logic          bus_cs_n,
   input  logic          bus_rd_n,
   input  logic          bus_wr_n,
   input  logic [AW-1:0] bus_addr,
   inout  wire  [DW-1:0] bus_data
);

   generate
      if ((1 << PW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (DW < PW + 1 || DW < SW) begin : g_bad_width
         $error("DW too narrow for status word or sample");
      end
   endgenerate

   cap_rgn_e      rgn;
   logic          rd_req, wr_req, clr_wrap;
   logic [PW-1:0] wptr;
   logic          wrap_flag;
   logic [SW-1:0] mem_q;
   logic          sel_ctrl_q;
   logic [DW-1:0] status_w, status_q, dout;
   logic          bus_oe;

   assign rgn      = rgn_of(bus_addr[PW]);
   assign rd_req   = !bus_cs_n && !bus_rd_n;
   assign wr_req   = !bus_cs_n && !bus_wr_n;
   assign clr_wrap = wr_req && (rgn == RGN_CTRL);

   cap_wptr #(.DEPTH(DEPTH)) u_wptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (smp_valid),
      .clr_wrap (clr_wrap),
      .ptr      (wptr),
      .wrap     (wrap_flag)
   );

   cap_mem #(.DEPTH(DEPTH), .SW(SW)) u_mem (
      .clk   (clk),
      .we    (smp_valid),
      .waddr (wptr),
      .wdata (smp_data),
      .re    (rd_req && (rgn == RGN_SAMPLE)),
      .raddr (bus_addr[PW-1:0]),
      .rdata (mem_q)
   );

   always_comb begin
      status_w           = '0;
      status_w[PW-1:0]   = wptr;
      status_w[DW-1]     = wrap_flag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_ctrl_q <= 1'b0;
         status_q   <= '0;
      end else if (rd_req) begin
         sel_ctrl_q <= (rgn == RGN_CTRL);
         if (rgn == RGN_CTRL) status_q <= status_w;
      end
   end

   assign dout = sel_ctrl_q ? status_q : DW'(mem_q);

   cap_busio #(.DW(DW)) u_busio (
      .cs_n (bus_cs_n),
      .rd_n (bus_rd_n),
      .dout (dout),
      .oe   (bus_oe),
      .pad  (bus_data)
   );

endmodule

// File: rtl/cap_ring_chk.sv
module cap_ring_chk #(
   parameter int PW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_valid,
   input logic          bus_cs_n,
   input logic          bus_rd_n,
   input logic          bus_wr_n,
   input logic          ctrl_hit,
   input logic          bus_oe,
   input logic [PW-1:0] wptr,
   input logic          wrap_flag
);

   localparam logic [PW-1:0] LAST = '1;

   // R9: bus released unless selected for a read
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs_n || bus_rd_n) |-> !bus_oe);

   // R2: pointer advances by one per valid sample
   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> wptr == $past(wptr) + 1'b1);

   // R2: pointer holds without a sample
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(wptr));

   // R6: wrap flag rises only on a roll-over from the last index
   a_r6_wrap_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrap_flag) |-> ($past(smp_valid) && $past(wptr) == LAST));

   // R7: control write clears the flag when no wrap coincides
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && !bus_wr_n && ctrl_hit && !(smp_valid && wptr == LAST))
      |=> !wrap_flag);

endmodule

bind cap_ring_buf cap_ring_chk #(.PW(PW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .bus_cs_n  (bus_cs_n),
   .bus_rd_n  (bus_rd_n),
   .bus_wr_n  (bus_wr_n),
   .ctrl_hit  (bus_addr[PW]),
   .bus_oe    (bus_oe),
   .wptr      (wptr),
   .wrap_flag (wrap_flag)
);

// File: tb/cap_ring_buf_test.sv
module cap_ring_buf_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] FOREIGN = 16'h5A3C;

   typedef struct packed {
      logic [9:0]  addr;
      logic [15:0] expect_v;
   } rd_vec_t;

   localparam rd_vec_t VECS [8] = '{
      '{10'd0,   16'h0003},
      '{10'd1,   16'h000A},
      '{10'd2,   16'h0001},
      '{10'd100, 16'h000F},
      '{10'd256, 16'h0003},
      '{10'd511, 16'h000C},
      '{10'h200, 16'h8000},
      '{10'h3FF, 16'h8000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [3:0]  smp_data = '0;
   logic        bus_cs_n = 1'b1;
   logic        bus_rd_n = 1'b1;
   logic        bus_wr_n = 1'b1;
   logic [9:0]  bus_addr = '0;
   logic        tb_en = 1'b0;
   logic [15:0] tb_drv = '0;
   wire  [15:0] bus_data;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   assign bus_data = tb_en ? tb_drv : 16'bz;

   always #(CLK_PERIOD/2) clk = ~clk;

   cap_ring_buf uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .bus_cs_n  (bus_cs_n),
      .bus_rd_n  (bus_rd_n),
      .bus_wr_n  (bus_wr_n),
      .bus_addr  (bus_addr),
      .bus_data  (bus_data)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp_v);
      tests++;
      if (act !== exp_v) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
      end
   endtask

   task automatic host_read(input logic [9:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_addr = a; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
      @(negedge clk);
      v = bus_data;
      bus_cs_n = 1'b1; bus_rd_n = 1'b1;
   endtask

   task automatic host_write(input logic [9:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_cs_n = 1'b0; bus_wr_n = 1'b0; tb_en = 1'b1; tb_drv = d;
      @(negedge clk);
      bus_cs_n = 1'b1; bus_wr_n = 1'b1; tb_en = 1'b0;
   endtask

   task automatic feed(input int first, input int count);
      for (int i = first; i < first + count; i++) begin
         @(negedge clk);
         smp_valid = 1'b1;
         smp_data  = 4'((i * 7 + 3) % 16);
      end
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state via status word, and bus released
      host_read(10'h200, v);
      check("R1 status after reset", v, 16'h0000);
      @(negedge clk);
      tb_en = 1'b1; tb_drv = FOREIGN;
      @(negedge clk);
      check("R1 bus released after reset", bus_data, FOREIGN);
      tb_en = 1'b0;

      // R2: partial fill, then idle cycles
      feed(0, 5);
      repeat (4) @(negedge clk);
      host_read(10'h200, v);
      check("R2 pointer after 5 samples", v, 16'h0005);

      // R6: complete the lap
      feed(5, 507);
      host_read(10'h200, v);
      check("R6 wrap set, pointer 0", v, 16'h8000);

      // R3/R5 vector table
      foreach (VECS[k]) begin
         host_read(VECS[k].addr, v);
         check(VECS[k].addr[9] ? "R5 status read" : "R3 sample read", v, VECS[k].expect_v);
      end

      // R8: host write to sample region is ignored
      host_write(10'd1, 16'hFFFF);
      host_read(10'd1, v);
      check("R8 sample write ignored", v, 16'h000A);

      // R7: control write clears wrap
      host_write(10'h200, 16'h0000);
      host_read(10'h200, v);
      check("R7 wrap cleared", v, 16'h0000);

      // R4: read-first collision at index 0
      @(negedge clk);
      bus_addr = 10'd0; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
      smp_valid = 1'b1; smp_data = 4'd9;
      @(negedge clk);
      smp_valid = 1'b0;
      check("R4 collision returns old", bus_data, 16'h0003);
      bus_cs_n = 1'b1; bus_rd_n = 1'b1;
      host_read(10'd0, v);
      check("R4 new value stored", v, 16'h0009);

      // R9: release with only one strobe active
      @(negedge clk);
      bus_cs_n = 1'b1; bus_rd_n = 1'b0; tb_en = 1'b1; tb_drv = FOREIGN;
      @(negedge clk);
      check("R9 released, cs high", bus_data, FOREIGN);
      bus_cs_n = 1'b0; bus_rd_n = 1'b1; tb_drv = ~FOREIGN;
      @(negedge clk);
      check("R9 released, rd high", bus_data, ~FOREIGN);
      bus_cs_n = 1'b1; tb_en = 1'b0;

      // R7: set wins over a simultaneous clear
      feed(0, 510);
      @(negedge clk);
      bus_addr = 10'h200; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
      smp_valid = 1'b1; smp_data = 4'd1;
      @(negedge clk);
      smp_valid = 1'b0; bus_cs_n = 1'b1; bus_wr_n = 1'b1;
      host_read(10'h200, v);
      check("R7 set wins over clear", v, 16'h8000);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule